// File: doc/BRIEF.md
# Shared Nibble Memory Access Sequencer

This block lets a display engine and a processor share one DRAM that is only four bits wide and takes a multiplexed row and column address. Every eight clocks form one access window. A one-hot ring of eight slots steps through the window. In the window the block sends a row address, then two column addresses, and reads one nibble after each. The two nibbles make one byte. A display fetch gets the window when one is due. Otherwise the processor's address passes through, and the assembled byte is returned as processor read data.

The block also holds the screen pointer, which uses character-cell addressing. Each byte fetched moves the pointer on by the number of pixel lines in a character row. A new pixel line inside a row starts one byte after the previous line's start. After the last line of a row, the pointer steps back to the first line of the next character column. A pointer that reaches the top of screen memory wraps back by the size of the screen area. The screen area's size and base, and the spacing of display fetches, all follow from a two-bit bytes-per-line select and a short-rows select.

Top module: `vid_dram_seq`

## Requirements
- R1: While reset is held, and at the clock after it is released, both strobes are inactive, `pix_valid` is 0, `pix_byte` and `cpu_rdata` are 0, and `ram_addr` is 0. The ring starts in slot 7, so the first window begins at the first clock edge after release.
- R2: A window is 8 clocks numbered 0 to 7. The row strobe is active in slots 1 to 6. The column strobe is active in slots 2, 3, 5 and 6, and never outside the row strobe. Each row-strobe period lasts exactly six clocks. Strobes are active high with the default `STROBE_LOW`=0.
- R3: For the window address A, `ram_addr` is A[15:7] in slots 0 and 7. It is {A[6:0],0} in slots 1 to 3 and {A[6:0],1} in slots 4 to 6. It does not change while the column strobe stays active.
- R4: The nibble on `ram_nib` in slot 3 becomes bits 7:4 of the byte. The nibble in slot 6 becomes bits 3:0.
- R5: The source for a window is decided at the edge that ends slot 7. A display fetch is taken only if `nmi_busy` is 0, the fetch divider is 0, `pix_window` is 1 and `row_gap` is 0. Otherwise `cpu_addr` is used. The choice holds for the whole window.
- R6: The fetch divider counts windows modulo 2^`cfg_bpl_sel`. A line then holds 80>>`cfg_bpl_sel` bytes. A `frame_start` or `line_step` pulse clears the divider.
- R7: Each display byte adds 8 to the screen pointer. A result of 0x8000 or more has the screen area size subtracted from it.
- R8: On `line_step`, the pointer becomes the current line's start address plus 1. On the step after the 8th line of a character row, it instead becomes the current pointer minus 7. The same wrap is applied, and the result becomes the new line's start address.
- R9: The screen area base is (0x8000 − bytes_per_line×8×rows) rounded down to a multiple of 256. Rows is 25 when `cfg_short_rows` is 1 and 32 otherwise. The area size is 0x8000 minus the base. `frame_start` loads the base into the pointer and the line start, and sets the line index to 0.
- R10: After a display window, `pix_valid` is 1 for exactly slot 7 and `pix_byte` holds the byte, while `cpu_rdata` is unchanged. After a processor window, `cpu_rdata` takes the byte, `pix_byte` is unchanged and `pix_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bpl_sel | input | 2 | Bytes-per-line select: 80>>sel bytes, fetch every 2^sel windows |
| cfg_short_rows | input | 1 | 1 selects 25 character rows, 0 selects 32 |
| nmi_busy | input | 1 | Blocks display fetches while high |
| pix_window | input | 1 | Beam is inside the pixel window |
| row_gap | input | 1 | Blank spacing between rows is pending |
| frame_start | input | 1 | Reload screen pointer from the base |
| line_step | input | 1 | Advance to the next pixel line |
| cpu_addr | input | 16 | Processor address |
| ram_nib | input | 4 | Nibble read from the DRAM |
| ram_addr | output | 9 | Multiplexed DRAM address |
| row_sel | output | 1 | Row address strobe |
| col_sel | output | 1 | Column address strobe |
| pix_byte | output | 8 | Last assembled display byte |
| pix_valid | output | 1 | One-clock pulse with a new display byte |
| cpu_rdata | output | 8 | Last assembled processor byte |

## Verification
The bench uses a nibble memory whose contents are a function of the address, so a wrong row, a swapped column bit or swapped nibble halves changes every byte read. It covers all four bytes-per-line settings. Against the geometry formula, a rounding error in the screen base moves every display byte. One long sweep walks every character row of the 32-row mode and reads one byte past the end of the last line, so a missing wrap reads from 0x8007 instead of the base plus 7. Processor windows are placed where a fetch would be due, using NMI, row gap and a closed pixel window. A design that ignored any of these, or that mis-counted the divider, would take or skip the wrong windows and break the valid-pulse checks.

// File: rtl/vds_pkg.sv
package vds_pkg;
   // slot numbers of the access ring; the order is the DRAM protocol
   localparam int SLOT_N     = 8;
   localparam int SL_ROW     = 0;
   localparam int SL_RAS     = 1;
   localparam int SL_CAS_HI  = 2;
   localparam int SL_GET_HI  = 3;
   localparam int SL_COL_LO  = 4;
   localparam int SL_CAS_LO  = 5;
   localparam int SL_GET_LO  = 6;
   localparam int SL_IDLE    = 7;
endpackage

// File: rtl/vds_slot_ring.sv
module vds_slot_ring #(
   parameter int N    = 8,
   parameter int INIT = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [N-1:0] slot
);
   localparam logic [N-1:0] INIT_V = N'(1) << INIT;

   if (INIT >= N) begin : g_bad_init
      $error("ring start slot outside the ring");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) slot <= INIT_V;
      else        slot <= {slot[N-2:0], slot[N-1]};
   end
endmodule

// File: rtl/vds_scr_ptr.sv
module vds_scr_ptr #(
   parameter int AW    = 16,
   parameter int LINES = 8,
   parameter int TOP   = 32768
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          line_step,
   input  logic          byte_step,
   input  logic [AW-1:0] base_a,
   input  logic [AW-1:0] wrap_sz,
   output logic [AW-1:0] ptr
);
   localparam int LW = $clog2(LINES);

   logic [AW-1:0] line_base;
   logic [LW-1:0] lin, lin_nx;
   logic [AW-1:0] step_raw, step_w, byte_raw, byte_w;

   function automatic logic [AW-1:0] wrapf(input logic [AW-1:0] a, input logic [AW-1:0] sz);
      return (a >= AW'(TOP)) ? a - sz : a;
   endfunction

   always_comb begin
      lin_nx   = lin + 1'b1;
      step_raw = (lin_nx == '0) ? ptr - AW'(LINES - 1) : line_base + AW'(1);
      step_w   = wrapf(step_raw, wrap_sz);
      byte_raw = ptr + AW'(LINES);
      byte_w   = wrapf(byte_raw, wrap_sz);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr       <= '0;
         line_base <= '0;
         lin       <= '0;
      end else if (load) begin
         ptr       <= base_a;
         line_base <= base_a;
         lin       <= '0;
      end else if (line_step) begin
         ptr       <= step_w;
         line_base <= step_w;
         lin       <= lin_nx;
      end else if (byte_step) begin
         ptr       <= byte_w;
      end
   end
endmodule

// File: rtl/vds_nib_pack.sv
module vds_nib_pack #(
   parameter int NW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_hi,
   input  logic          take_lo,
   input  logic          to_disp,
   input  logic [NW-1:0] nib,
   output logic [2*NW-1:0] pix_byte,
   output logic          pix_valid,
   output logic [2*NW-1:0] cpu_rdata
);
   logic [NW-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q      <= '0;
         pix_byte  <= '0;
         cpu_rdata <= '0;
         pix_valid <= 1'b0;
      end else begin
         pix_valid <= take_lo && to_disp;
         if (take_hi) hi_q <= nib;
         if (take_lo) begin
            if (to_disp) pix_byte  <= {hi_q, nib};
            else         cpu_rdata <= {hi_q, nib};
         end
      end
   end
endmodule

// File: rtl/vid_dram_seq.sv
module vid_dram_seq
   import vds_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NIB_W      = 4,
   parameter int COL_BITS   = 7,
   parameter int LINES      = 8,
   parameter int MAX_BPL    = 80,
   parameter int TALL_ROWS  = 32,
   parameter int SHORT_ROWS = 25,
   parameter int TOP_ADDR   = 32768,
   parameter int ALIGN      = 256,
   parameter int SEL_W      = 2,
   parameter bit STROBE_LOW = 1'b0,
   localparam int RA_W      = ADDR_W - COL_BITS,
   localparam int BYTE_W    = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  cfg_bpl_sel,
   input  logic              cfg_short_rows,
   input  logic              nmi_busy,
   input  logic              pix_window,
   input  logic              row_gap,
   input  logic              frame_start,
   input  logic              line_step,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [NIB_W-1:0]  ram_nib,
   output logic [RA_W-1:0]   ram_addr,
   output logic              row_sel,
   output logic              col_sel,
   output logic [BYTE_W-1:0] pix_byte,
   output logic              pix_valid,
   output logic [BYTE_W-1:0] cpu_rdata
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   if (RA_W < COL_BITS + 1) begin : g_bad_ra
      $error("DRAM address too narrow for the column field");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("lines per row must be a power of two");
   end
   if (TOP_ADDR >= (1 << ADDR_W) || (ALIGN & (ALIGN - 1)) != 0) begin : g_bad_top
      $error("screen top or alignment out of range");
   end

   logic [SLOT_N-1:0] slot;
   logic [ADDR_W-1:0] bpl_v, rows_v, used_v, base_v, wrap_v;
   logic [ADDR_W-1:0] scr_ptr, acc_addr;
   logic [DIV_W:0]    span;
   logic [DIV_W-1:0]  div_mask, div_q;
   logic              fetch_due, take_disp;
   logic              ras_act, cas_act;
   logic [RA_W-1:0]   row_a, col0_a, col1_a;

   vds_slot_ring #(.N(SLOT_N), .INIT(SL_IDLE)) u_ring (
      .clk (clk), .rst_n (rst_n), .slot (slot)
   );

   // screen geometry from the mode selects
   always_comb begin
      bpl_v    = ADDR_W'(MAX_BPL) >> cfg_bpl_sel;
      rows_v   = cfg_short_rows ? ADDR_W'(SHORT_ROWS) : ADDR_W'(TALL_ROWS);
      used_v   = bpl_v * ADDR_W'(LINES) * rows_v;
      base_v   = (ADDR_W'(TOP_ADDR) - used_v) & ~ADDR_W'(ALIGN - 1);
      wrap_v   = ADDR_W'(TOP_ADDR) - base_v;
      span     = (DIV_W+1)'(1) << cfg_bpl_sel;
      div_mask = DIV_W'(span - 1'b1);
   end

   assign fetch_due = !nmi_busy && (div_q == '0) && pix_window && !row_gap;

   // source choice and fetch divider, both stepped at the end of slot 7
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q     <= '0;
         take_disp <= 1'b0;
         acc_addr  <= '0;
      end else begin
         if (frame_start || line_step) div_q <= '0;
         else if (slot[SL_IDLE])       div_q <= DIV_W'(div_q + 1'b1) & div_mask;
         if (slot[SL_IDLE]) begin
            take_disp <= fetch_due;
            acc_addr  <= fetch_due ? scr_ptr : cpu_addr;
         end
      end
   end

   vds_scr_ptr #(.AW(ADDR_W), .LINES(LINES), .TOP(TOP_ADDR)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_start),
      .line_step (line_step),
      .byte_step (take_disp && slot[SL_GET_LO]),
      .base_a    (base_v),
      .wrap_sz   (wrap_v),
      .ptr       (scr_ptr)
   );

   // address multiplexing per slot
   always_comb begin
      row_a   = acc_addr[ADDR_W-1:COL_BITS];
      col0_a  = RA_W'({acc_addr[COL_BITS-1:0], 1'b0});
      col1_a  = RA_W'({acc_addr[COL_BITS-1:0], 1'b1});
      ras_act = slot[SL_RAS] | slot[SL_CAS_HI] | slot[SL_GET_HI]
              | slot[SL_COL_LO] | slot[SL_CAS_LO] | slot[SL_GET_LO];
      cas_act = slot[SL_CAS_HI] | slot[SL_GET_HI] | slot[SL_CAS_LO] | slot[SL_GET_LO];
      if (slot[SL_ROW] | slot[SL_IDLE])                       ram_addr = row_a;
      else if (slot[SL_RAS] | slot[SL_CAS_HI] | slot[SL_GET_HI]) ram_addr = col0_a;
      else                                                    ram_addr = col1_a;
   end

   if (STROBE_LOW) begin : g_strobe_low
      assign row_sel = ~ras_act;
      assign col_sel = ~cas_act;
   end else begin : g_strobe_high
      assign row_sel = ras_act;
      assign col_sel = cas_act;
   end

   vds_nib_pack #(.NW(NIB_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_hi   (slot[SL_GET_HI]),
      .take_lo   (slot[SL_GET_LO]),
      .to_disp   (take_disp),
      .nib       (ram_nib),
      .pix_byte  (pix_byte),
      .pix_valid (pix_valid),
      .cpu_rdata (cpu_rdata)
   );
endmodule

// File: rtl/vds_checker.sv
module vds_checker #(
   parameter int RA_W   = 9,
   parameter int ADDR_W = 16,
   parameter int TOP    = 32768
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_act,
   input logic              cas_act,
   input logic [RA_W-1:0]   ram_addr,
   input logic              pix_valid,
   input logic [ADDR_W-1:0] scr_ptr
);
   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      cas_act |-> ras_act);                                          // R2
   AST_RAS_SIX_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_act) |-> $past(ras_act, 6));                         // R2
   AST_ADDR_HELD_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_act && $past(cas_act)) |-> $stable(ram_addr));            // R3
   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_valid) |-> ($past(cas_act) && !cas_act));            // R4
   AST_PTR_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      scr_ptr < ADDR_W'(TOP));                                       // R7
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> !pix_valid);                                     // R10
endmodule

bind vid_dram_seq vds_checker #(
   .RA_W (RA_W), .ADDR_W (ADDR_W), .TOP (TOP_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ras_act   (ras_act),
   .cas_act   (cas_act),
   .ram_addr  (ram_addr),
   .pix_valid (pix_valid),
   .scr_ptr   (scr_ptr)
);

// File: tb/tb_vid_dram_seq.sv
module tb_vid_dram_seq;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [1:0]  sel = 2'd3;
   logic        short_rows = 1'b1;
   logic        nmi_busy = 1'b0, pix_window = 1'b0, row_gap = 1'b0;
   logic        frame_start = 1'b0, line_step = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [3:0]  ram_nib = '0;
   logic [8:0]  ram_addr;
   logic        row_sel, col_sel, pix_valid;
   logic [7:0]  pix_byte, cpu_rdata;

   int n_chk = 0, n_bad = 0, cpu_cnt = 0;
   int g_bpl, g_period, g_base, g_wsz;

   vid_dram_seq dut (
      .clk (clk), .rst_n (rst_n), .cfg_bpl_sel (sel), .cfg_short_rows (short_rows),
      .nmi_busy (nmi_busy), .pix_window (pix_window), .row_gap (row_gap),
      .frame_start (frame_start), .line_step (line_step), .cpu_addr (cpu_addr),
      .ram_nib (ram_nib), .ram_addr (ram_addr), .row_sel (row_sel), .col_sel (col_sel),
      .pix_byte (pix_byte), .pix_valid (pix_valid), .cpu_rdata (cpu_rdata)
   );

   // nibble memory: contents are a function of the latched row and column
   function automatic logic [3:0] nib_of(input logic [8:0] r, input logic [8:0] c);
      logic [8:0] t;
      t = r * 9'd5 + c * 9'd3 + (c >> 4) + (r >> 3);
      return t[3:0];
   endfunction

   logic [8:0] rlat = '0, clat = '0, prev_addr = '0;
   logic       prev_rs = 1'b0, prev_cs = 1'b0;
   always @(negedge clk) begin
      if (row_sel && !prev_rs) rlat = prev_addr;
      if (col_sel && !prev_cs) clat = prev_addr;
      prev_rs   = row_sel;
      prev_cs   = col_sel;
      prev_addr = ram_addr;
      ram_nib   = nib_of(rlat, clat);
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called in slot 7; returns in the following slot 7
   task automatic window(input bit pw, input bit nm, input bit gp, input bit fs,
                         input bit ls, input bit ed, input logic [15:0] ea, input string tag);
      logic [15:0] ca, a;
      logic [7:0]  eb, old_pix, old_cpu;
      cpu_cnt++;
      ca = 16'(cpu_cnt * 40503 + 4660);
      pix_window = pw; nmi_busy = nm; row_gap = gp;
      frame_start = fs; line_step = ls; cpu_addr = ca;
      a  = ed ? ea : ca;
      eb = {nib_of(a[15:7], {1'b0, a[6:0], 1'b0}), nib_of(a[15:7], {1'b0, a[6:0], 1'b1})};
      old_pix = pix_byte; old_cpu = cpu_rdata;
      @(negedge clk);
      frame_start = 1'b0; line_step = 1'b0;
      chk("R3 row address in slot 0", int'(ram_addr), int'(a[15:7]));
      chk("R2 row strobe off in slot 0", int'(row_sel), 0);
      @(negedge clk);
      chk("R3 first column address", int'(ram_addr), int'({a[6:0], 1'b0}));
      chk("R2 row strobe in slot 1", int'(row_sel), 1);
      chk("R2 column strobe off in slot 1", int'(col_sel), 0);
      @(negedge clk);
      chk("R2 column strobe in slot 2", int'(col_sel), 1);
      @(negedge clk);
      @(negedge clk);
      chk("R3 second column address", int'(ram_addr), int'({a[6:0], 1'b1}));
      chk("R2 column strobe off in slot 4", int'(col_sel), 0);
      @(negedge clk);
      chk("R2 column strobe in slot 5", int'(col_sel), 1);
      @(negedge clk);
      chk("R2 row strobe in slot 6", int'(row_sel), 1);
      @(negedge clk);
      chk("R2 strobes off in slot 7", int'({row_sel, col_sel}), 0);
      if (ed) begin
         chk({"R5 R6 fetch taken ", tag}, int'(pix_valid), 1);
         chk({"R4 display byte ", tag}, int'(pix_byte), int'(eb));
         chk("R10 cpu data kept on display window", int'(cpu_rdata), int'(old_cpu));
      end else begin
         chk({"R5 R6 no fetch ", tag}, int'(pix_valid), 0);
         chk("R4 R10 cpu read byte", int'(cpu_rdata), int'(eb));
         chk("R10 pixel byte kept on cpu window", int'(pix_byte), int'(old_pix));
      end
   endtask

   task automatic frame_begin(input logic [1:0] s, input bit sh);
      sel = s; short_rows = sh;
      g_bpl    = 80 >> s;
      g_period = 1 << s;
      g_base   = (32768 - g_bpl * 8 * (sh ? 25 : 32)) & 32'hFFFF_FF00;  // R9
      g_wsz    = 32768 - g_base;
      window(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, "frame load");
   endtask

   function automatic logic [15:0] exp_addr(input int row, input int lin, input int k);
      int off;
      off = row * 8 * g_bpl + lin + 8 * k;        // R7 R8 R9
      return 16'(g_base + off % g_wsz);
   endfunction

   task automatic do_line(input int row, input int lin, input int nwin, input bit inj,
                          input string tag);
      int k = 0;
      for (int j = 0; j < nwin; j++) begin
         bit nm, gp, pw, ed;
         nm = inj && (j == 16);
         gp = inj && (j == 32);
         pw = !(inj && (j == 48));
         ed = pw && !nm && !gp && (j % g_period == 0);
         window(pw, nm, gp, 1'b0, 1'b0, ed, exp_addr(row, lin, k), tag);
         if (ed) k++;
      end
   endtask

   task automatic step();
      window(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, "line step");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, ring still in slot 7
      chk("R1 row strobe after reset", int'(row_sel), 0);
      chk("R1 column strobe after reset", int'(col_sel), 0);
      chk("R1 valid after reset", int'(pix_valid), 0);
      chk("R1 pixel byte after reset", int'(pix_byte), 0);
      chk("R1 cpu data after reset", int'(cpu_rdata), 0);
      chk("R1 address after reset", int'(ram_addr), 0);

      // 10 bytes per line, 25 rows: base 0x7800, fetch every 8 windows
      frame_begin(2'd3, 1'b1);
      chk("R9 base for 10-byte short mode", g_base, 32'h7800);
      for (int lin = 0; lin < 9; lin++) begin
         if (lin > 0) step();
         do_line(lin / 8, lin % 8, 80, lin == 8, "R8 mode 10x25");
      end

      // 40 bytes per line, 32 rows: walk to the last row and read past the end
      frame_begin(2'd1, 1'b0);
      for (int row = 0; row < 32; row++) begin
         for (int lin = 0; lin < 8; lin++) begin
            if (row != 0 || lin != 0) step();
            if (lin == 7) do_line(row, 7, (row == 31) ? 82 : 80, 1'b0, "R7 wrap mode 40x32");
         end
      end

      // 80 bytes per line, 25 rows: base rounded down to 0x4100
      frame_begin(2'd0, 1'b1);
      chk("R9 base for 80-byte short mode", g_base, 32'h4100);
      for (int lin = 0; lin < 9; lin++) begin
         if (lin > 0) step();
         do_line(lin / 8, lin % 8, 80, lin == 8, "R6 mode 80x25");
      end

      // 20 bytes per line, 25 rows: base 0x7000
      frame_begin(2'd2, 1'b1);
      do_line(0, 0, 80, 1'b1, "R9 mode 20x25");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule